// File: doc/BRIEF.md
# Transmit Frame Assembler

The block builds an outgoing Ethernet frame from a sequence of 32-bit host writes to one data port and replays it as a byte stream. The first write of a frame is a header word: its low half gives the payload length, which does not count the 14-byte Ethernet header, and its upper half holds the first two frame bytes. Every later write adds four bytes to a local buffer.

Once the buffer holds at least the expected number of bytes, the assembler fixes the final frame length and streams the frame out, one byte per cycle. A room for a trailing checksum is reserved while collecting when checksum insertion is off, and removed again before sending. Frames shorter than the minimum size may be zero-padded. A completed frame produces a transmit-empty pulse. An oversize length puts the block into an error state, which only an acknowledge clears.

Top module: `tx_frame_asm`

## Requirements
- R1: After reset, wr_ready_o is 1 and tx_valid_o, tx_last_o, tx_empty_o and tx_err_o are all 0.
- R2: In idle, an accepted write starts a frame: wr_data_i[15:0] is the payload length L, wr_data_i[23:16] becomes frame byte 0 and wr_data_i[31:24] frame byte 1.
- R3: Each later accepted write stores four further frame bytes in order, wr_data_i[7:0] first and wr_data_i[31:24] last.
- R4: With crc_ins_i at 0 the expected count is L+18; the frame is not sent while fewer bytes have been collected, and the sent length is L+14.
- R5: With pad_en_i at 1 and L+14 below 60, exactly 60 bytes are sent, bytes from index L+14 up being 0x00.
- R6: With crc_ins_i at 1 the expected count is L+14; with pad_en_i at 0 or L+14 of 60 or more, exactly L+14 bytes are sent.
- R7: Frame bytes leave on consecutive cycles with tx_valid_o high; tx_last_o is high on the final byte only.
- R8: tx_empty_o is a one-cycle pulse in the cycle after the byte that carries tx_last_o.
- R9: A header write with L above 2032 sets tx_err_o in the next cycle and sends nothing; L of 2032 is accepted.
- R10: While tx_err_o is high, data writes are ignored; err_ack_i clears tx_err_o and the next write is taken as a new header word.
- R11: err_ack_i during collection discards the partial frame; the next write is a header word.
- R12: wr_ready_o is 0 from the cycle after the completing write until the cycle of the final byte; writes offered while it is 0 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Data write strobe |
| wr_data_i | input | 32 | Data write value |
| crc_ins_i | input | 1 | Checksum inserted downstream (no allowance) |
| pad_en_i | input | 1 | Pad short frames to minimum size |
| err_ack_i | input | 1 | Acknowledge of transmit error; resets assembler |
| wr_ready_o | output | 1 | Writes are accepted |
| tx_data_o | output | 8 | Frame byte |
| tx_valid_o | output | 1 | tx_data_o carries a frame byte |
| tx_last_o | output | 1 | Final byte of the frame |
| tx_empty_o | output | 1 | One-cycle pulse after a frame is sent |
| tx_err_o | output | 1 | Oversize length seen, awaiting acknowledge |

## Verification
Byte i of a frame appears after the (i+1)-th rising edge following the edge that took the completing write, tx_empty_o one edge after the last byte, and tx_err_o and the stall one edge after the write that caused them. The bench drives inputs and samples outputs on falling edges, so each check lands exactly on the first cycle a result is due. It sweeps every payload length from 0 to 60 under all four checksum and padding settings, so the padding boundary and the early-send window are both crossed, and then covers the largest legal length, oversize lengths, acknowledge in both states, and writes offered during a send.

// File: rtl/tfa_pkg.sv
package tfa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_SEND    = 2'd2,
    ST_ERR     = 2'd3
  } tfa_state_e;
endpackage

// File: rtl/tfa_buf.sv
module tfa_buf #(
  parameter int BUF_BYTES = 2048,
  parameter int CW        = 12,
  localparam int AW       = $clog2(BUF_BYTES)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [CW-1:0] waddr_i,
  input  logic [3:0]    wmask_i,
  input  logic [31:0]   wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [BUF_BYTES];

  // lanes beyond the buffer carry only checksum allowance; drop them
  always_ff @(posedge clk_i) begin
    for (int k = 0; k < 4; k++) begin
      if (we_i && wmask_i[k] && ((waddr_i + CW'(k)) < CW'(BUF_BYTES)))
        mem_q[AW'(waddr_i + CW'(k))] <= wdata_i[8*k +: 8];
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tfa_ctrl.sv
module tfa_ctrl import tfa_pkg::*; #(
  parameter int MAX_LEN   = 2032,
  parameter int HDR_BYTES = 14,
  parameter int CRC_BYTES = 4,
  parameter int MIN_FRAME = 60,
  parameter int CW        = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [31:0]   wr_data_i,
  input  logic          crc_ins_i,
  input  logic          pad_en_i,
  input  logic          err_ack_i,
  input  logic          done_i,
  output logic          ready_o,
  output logic          send_o,
  output logic          err_o,
  output logic [CW-1:0] final_len_o,
  output logic [CW-1:0] send_len_o,
  output logic          bw_en_o,
  output logic [CW-1:0] bw_addr_o,
  output logic [3:0]    bw_mask_o,
  output logic [31:0]   bw_data_o
);
  tfa_state_e    state_q;
  logic [CW-1:0] cnt_q, exp_q, fin_q, snd_q;
  logic [15:0]   len_w;
  logic          take, len_bad;
  logic [CW-1:0] exp_d, cnt_nx, fin_d, snd_d;

  assign ready_o = (state_q != ST_SEND);
  assign send_o  = (state_q == ST_SEND);
  assign err_o   = (state_q == ST_ERR);

  assign len_w   = wr_data_i[15:0];
  assign take    = wr_en_i && ready_o && !err_ack_i;
  assign len_bad = (len_w > 16'(MAX_LEN));
  assign exp_d   = CW'(len_w) + CW'(HDR_BYTES) + (crc_ins_i ? '0 : CW'(CRC_BYTES));
  assign cnt_nx  = cnt_q + CW'(4);
  assign fin_d   = crc_ins_i ? exp_q : exp_q - CW'(CRC_BYTES);
  assign snd_d   = (pad_en_i && (fin_d < CW'(MIN_FRAME))) ? CW'(MIN_FRAME) : fin_d;

  always_comb begin
    bw_en_o   = take && (((state_q == ST_IDLE) && !len_bad) || (state_q == ST_COLLECT));
    bw_addr_o = (state_q == ST_IDLE) ? '0 : cnt_q;
    bw_mask_o = (state_q == ST_IDLE) ? 4'b0011 : 4'b1111;
    bw_data_o = (state_q == ST_IDLE) ? {16'h0, wr_data_i[31:16]} : wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      exp_q   <= '0;
      fin_q   <= '0;
      snd_q   <= '0;
    end else if (err_ack_i && state_q != ST_SEND) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (take) begin
          if (len_bad) begin
            state_q <= ST_ERR;
          end else begin
            state_q <= ST_COLLECT;
            exp_q   <= exp_d;
            cnt_q   <= CW'(2);
          end
        end
        ST_COLLECT: if (take) begin
          cnt_q <= cnt_nx;
          if (cnt_nx >= exp_q) begin
            fin_q   <= fin_d;
            snd_q   <= snd_d;
            state_q <= ST_SEND;
          end
        end
        ST_SEND: if (done_i) state_q <= ST_IDLE;
        default: state_q <= ST_ERR;
      endcase
    end
  end

  assign final_len_o = fin_q;
  assign send_len_o  = snd_q;
endmodule

// File: rtl/tfa_streamer.sv
module tfa_streamer #(
  parameter int BUF_BYTES = 2048,
  parameter int CW        = 12,
  localparam int AW       = $clog2(BUF_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          send_i,
  input  logic [CW-1:0] final_len_i,
  input  logic [CW-1:0] send_len_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          done_o,
  output logic [7:0]    tx_data_o,
  output logic          tx_valid_o,
  output logic          tx_last_o,
  output logic          tx_empty_o
);
  logic [CW-1:0] idx_q;

  assign rd_addr_o = idx_q[AW-1:0];
  assign done_o    = send_i && (idx_q == send_len_i - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q      <= '0;
      tx_data_o  <= '0;
      tx_valid_o <= 1'b0;
      tx_last_o  <= 1'b0;
      tx_empty_o <= 1'b0;
    end else begin
      tx_valid_o <= send_i;
      tx_last_o  <= done_o;
      // bytes past the final length are padding
      tx_data_o  <= (send_i && idx_q < final_len_i) ? rd_data_i : 8'h00;
      idx_q      <= (send_i && !done_o) ? idx_q + CW'(1) : '0;
      tx_empty_o <= tx_valid_o && tx_last_o;
    end
  end
endmodule

// File: rtl/tx_frame_asm.sv
module tx_frame_asm #(
  parameter int BUF_BYTES = 2048,
  parameter int MAX_LEN   = 2032,
  parameter int HDR_BYTES = 14,
  parameter int CRC_BYTES = 4,
  parameter int MIN_FRAME = 60
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  input  logic        crc_ins_i,
  input  logic        pad_en_i,
  input  logic        err_ack_i,
  output logic        wr_ready_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_valid_o,
  output logic        tx_last_o,
  output logic        tx_empty_o,
  output logic        tx_err_o
);
  localparam int AW = $clog2(BUF_BYTES);
  localparam int CW = $clog2(BUF_BYTES + HDR_BYTES + CRC_BYTES + 8);

  logic          send, done, bw_en;
  logic [CW-1:0] final_len, send_len, bw_addr;
  logic [3:0]    bw_mask;
  logic [31:0]   bw_data;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;

  tfa_ctrl #(
    .MAX_LEN(MAX_LEN), .HDR_BYTES(HDR_BYTES), .CRC_BYTES(CRC_BYTES),
    .MIN_FRAME(MIN_FRAME), .CW(CW)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .crc_ins_i(crc_ins_i), .pad_en_i(pad_en_i), .err_ack_i(err_ack_i),
    .done_i(done), .ready_o(wr_ready_o), .send_o(send), .err_o(tx_err_o),
    .final_len_o(final_len), .send_len_o(send_len), .bw_en_o(bw_en),
    .bw_addr_o(bw_addr), .bw_mask_o(bw_mask), .bw_data_o(bw_data)
  );

  tfa_buf #(.BUF_BYTES(BUF_BYTES), .CW(CW)) u_buf (
    .clk_i(clk_i), .we_i(bw_en), .waddr_i(bw_addr), .wmask_i(bw_mask),
    .wdata_i(bw_data), .raddr_i(rd_addr), .rdata_o(rd_data)
  );

  tfa_streamer #(.BUF_BYTES(BUF_BYTES), .CW(CW)) u_stream (
    .clk_i(clk_i), .rst_ni(rst_ni), .send_i(send), .final_len_i(final_len),
    .send_len_i(send_len), .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .done_o(done), .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o),
    .tx_last_o(tx_last_o), .tx_empty_o(tx_empty_o)
  );
endmodule

// File: rtl/tfa_checker.sv
module tfa_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic err_ack_i,
  input logic wr_ready_o,
  input logic tx_valid_o,
  input logic tx_last_o,
  input logic tx_empty_o,
  input logic tx_err_o
);
  AST_LAST_HAS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o |-> tx_valid_o); // R7
  AST_BYTES_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_last_o) |=> tx_valid_o); // R7
  AST_EMPTY_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_last_o) |=> tx_empty_o); // R8
  AST_EMPTY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |=> !tx_empty_o); // R8
  AST_ERR_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_err_o |-> !tx_valid_o); // R9
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_err_o && !err_ack_i) |=> tx_err_o); // R10
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_ack_i |=> !tx_err_o); // R10
  AST_STALL_IN_SEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_last_o) |-> !wr_ready_o); // R12
endmodule

bind tx_frame_asm tfa_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .err_ack_i(err_ack_i),
  .wr_ready_o(wr_ready_o), .tx_valid_o(tx_valid_o), .tx_last_o(tx_last_o),
  .tx_empty_o(tx_empty_o), .tx_err_o(tx_err_o)
);

// File: tb/sim_tx_frame_asm.sv
module sim_tx_frame_asm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        crc_ins = 1'b0;
  logic        pad_en = 1'b0;
  logic        err_ack = 1'b0;
  logic        wr_ready, tx_valid, tx_last, tx_empty, tx_err;
  logic [7:0]  tx_data;
  int          n_run = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  tx_frame_asm u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .crc_ins_i(crc_ins), .pad_en_i(pad_en), .err_ack_i(err_ack),
    .wr_ready_o(wr_ready), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .tx_last_o(tx_last), .tx_empty_o(tx_empty), .tx_err_o(tx_err)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(i * 13 + seed * 7 + 1);
  endfunction

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    err_ack = 1'b1;
    @(negedge clk);
    err_ack = 1'b0;
  endtask

  task automatic run_frame(input int len, input bit crc, input bit pad,
                           input int seed, input bit poke);
    int exp_cnt, fin, snd, cnt, nval;
    logic [7:0] eb;
    string dtag, ltag;
    crc_ins = crc;
    pad_en  = pad;
    exp_cnt = len + 14 + (crc ? 0 : 4);
    fin     = len + 14;
    snd     = (pad && fin < 60) ? 60 : fin;
    ltag    = (pad && fin < 60) ? "R5" : (crc ? "R6" : "R4");
    do_write({pat(seed, 1), pat(seed, 0), 16'(len)});
    cnt = 2;
    while (cnt < exp_cnt) begin
      do_write({pat(seed, cnt + 3), pat(seed, cnt + 2), pat(seed, cnt + 1), pat(seed, cnt)});
      cnt += 4;
      if (!crc && cnt >= fin && cnt < exp_cnt)
        chk(!tx_valid && wr_ready, "R4", "sent before allowance", int'(tx_valid), 0);
    end
    chk(!wr_ready, "R12", "ready after completing write", int'(wr_ready), 0);
    if (poke) begin
      wr_en   = 1'b1;
      wr_data = 32'hFFFF_FFFF;
    end
    nval = 0;
    for (int i = 0; i < snd; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (tx_valid) nval++;
      eb   = (i < fin) ? pat(seed, i) : 8'h00;
      dtag = (i < 2) ? "R2" : ((i < fin) ? "R3" : "R5");
      chk(tx_valid && tx_data == eb, dtag, "byte", int'(tx_data), int'(eb));
      chk(tx_last == (i == snd - 1), "R7", "last flag", int'(tx_last), int'(i == snd - 1));
      if (i < snd - 1)
        chk(!wr_ready, "R12", "ready during send", int'(wr_ready), 0);
    end
    chk(nval == snd, ltag, "frame length", nval, snd);
    @(negedge clk);
    chk(tx_empty && !tx_valid, "R8", "empty after last", int'(tx_empty), 1);
    chk(!tx_valid, ltag, "extra byte", int'(tx_valid), 0);
    @(negedge clk);
    chk(!tx_empty, "R8", "empty pulse width", int'(tx_empty), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_ready && !tx_valid && !tx_last && !tx_empty && !tx_err, "R1",
        "reset state", {wr_ready, tx_valid, tx_last, tx_empty, tx_err}, 5'b10000);

    // sweep across padding boundary and checksum allowance
    for (int c = 0; c < 2; c++)
      for (int p = 0; p < 2; p++)
        for (int l = 0; l <= 60; l++)
          run_frame(l, c[0], p[0], l + 3 * c + p, (l % 5) == 0);

    // largest legal length
    run_frame(2032, 1'b1, 1'b0, 9, 1'b0);
    chk(!tx_err, "R9", "2032 rejected", int'(tx_err), 0);
    run_frame(2032, 1'b0, 1'b1, 11, 1'b1);

    // oversize lengths
    for (int k = 0; k < 2; k++) begin
      do_write(k == 0 ? 32'hABCD_07F1 : 32'h1234_FFFF);
      chk(tx_err && !tx_valid, "R9", "oversize error", int'(tx_err), 1);
      do_write(32'h0000_0010);
      do_write(32'h5555_0004);
      do_write(32'h0000_0000);
      @(negedge clk);
      chk(tx_err && !tx_valid, "R10", "writes in error", int'(tx_valid), 0);
      pulse_ack();
      chk(!tx_err && wr_ready, "R10", "ack clears error", int'(tx_err), 0);
      run_frame(10 + k, 1'b1, 1'b1, 20 + k, 1'b0);
    end

    // acknowledge while collecting
    crc_ins = 1'b1;
    do_write({8'h11, 8'h22, 16'd40});
    do_write(32'hDEAD_BEEF);
    do_write(32'hCAFE_F00D);
    pulse_ack();
    chk(!tx_err && !tx_valid && wr_ready, "R11", "ack in collect", int'(tx_valid), 0);
    run_frame(5, 1'b0, 1'b1, 31, 1'b0);
    run_frame(50, 1'b1, 1'b0, 32, 1'b1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule